// File: doc/BRIEF.md
# Floating-Point NaN Propagation Selector

This unit sits directly behind a two-operand single-precision floating-point operation (addition or multiplication style) and fixes the bit pattern of any NaN that leaves it. It sees both IEEE 754 binary32 operands, the raw result from the arithmetic core and the core's invalid-operation flag. From these it decides whether the result is a plain number that passes through, a NaN carried over from one of the operands, or a NaN newly created by the operation.

Two policies choose the operand when both operands are NaN. The first-operand policy always takes operand A. The signaling-priority policy takes the signaling operand when one is signaling and the other is quiet. Any NaN carried over from an operand leaves with its quiet bit set. A newly created NaN gets a default pattern whose sign depends on the policy. An optional canonicalize enable replaces only newly created NaNs with one fixed pattern, so that results do not depend on the policy.

The corrected result and a NaN flag are registered with one cycle of latency and qualified by a valid strobe.

Top module: `nan_sel_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the unit clears `out_valid`, `res_out` and `nan_out` to 0.
- R2: `out_valid` is high in the cycle after an edge where `in_valid` was high, and low in the cycle after an edge where `in_valid` was low. The result belongs to the inputs sampled at that edge.
- R3: If neither operand is a NaN, `core_invalid` is low and `core_res` is not a NaN, then `res_out` equals `core_res` unchanged. A value is a NaN when bits [30:23] are all ones and bits [22:0] are non-zero, so infinities pass through.
- R4: If exactly one operand is a NaN, that operand is output with its sign and payload kept and bit 22 (the quiet bit, 1 = quiet) forced to 1, under either policy.
- R5: With `sig_prio` = 0 (first-operand policy) and both operands NaN, operand A is output with bit 22 forced to 1, whatever the quiet bits of A and B.
- R6: With `sig_prio` = 1 and both operands NaN, operand B is output (bit 22 set) only when A is quiet and B is signaling. Otherwise operand A is output (bit 22 set).
- R7: With `canon_en` = 0, no operand NaN, and either `core_invalid` high or `core_res` a NaN, the output is the default NaN: exponent all ones and fraction 0x400000. The sign is 1 when `sig_prio` = 0 (0xFFC00000) and 0 when `sig_prio` = 1 (0x7FC00000).
- R8: With `canon_en` = 1, the condition of R7 gives exactly 0x7FC00000 under either policy. A NaN carried over from an operand is not changed by `canon_en` and keeps its sign.
- R9: Whenever `out_valid` is high, `nan_out` is 1 exactly when `res_out` is a NaN.
- R10: After an edge where `in_valid` was low, `res_out` and `nan_out` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Inputs on this cycle are to be processed |
| op_a | input | 32 | First operand, binary32 |
| op_b | input | 32 | Second operand, binary32 |
| core_res | input | 32 | Raw result from the arithmetic core |
| core_invalid | input | 1 | Core raised invalid operation |
| sig_prio | input | 1 | 0 = first-operand policy, 1 = signaling-priority policy |
| canon_en | input | 1 | Force created NaNs to the canonical pattern |
| out_valid | output | 1 | `res_out` and `nan_out` carry a new result |
| res_out | output | 32 | Corrected result |
| nan_out | output | 1 | `res_out` is a NaN |

## Verification
The hardest case to reach is two NaN operands with mixed quiet bits under the signaling-priority policy. Only the order of quiet and signaling separates the B choice from the A choice, so the stimulus sends a quiet A with a signaling B, then the reverse, then two signaling NaNs, each with a distinct payload and sign so that the chosen operand can be told apart. A second hard case is a core that raises invalid while returning a non-NaN pattern. The bench drives exactly that to show that the flag alone creates a NaN.

// File: rtl/nan_sel_pkg.sv
// Package: shared types for the NaN propagation selector.
// Assumes binary floating-point formats with a quiet bit as the fraction MSB.
package nan_sel_pkg;

    // Classification of one floating-point value.
    typedef struct packed {
        logic is_nan;   // exponent all ones, fraction non-zero
        logic is_snan;  // NaN with quiet bit clear
    } nan_class_t;

    // Source selected for the final result.
    typedef enum logic [1:0] {
        SRC_CORE = 2'd0,  // pass the core result through
        SRC_A    = 2'd1,  // carry operand A (quieted)
        SRC_B    = 2'd2,  // carry operand B (quieted)
        SRC_GEN  = 2'd3   // emit a created NaN
    } nan_src_e;

endpackage

// File: rtl/nan_classify.sv
// Module: nan_classify
// Decides whether one value is a NaN and whether that NaN is signaling.
// Assumes the layout {sign, exponent[EXP_W], fraction[FRAC_W]}.
module nan_classify #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic [W-1:0]                value,
    output nan_sel_pkg::nan_class_t     cls
);
    logic exp_ones;
    logic frac_nz;

    // Detect the NaN encoding and inspect the quiet bit.
    always_comb begin
        exp_ones    = &value[W-2 -: EXP_W];
        frac_nz     = |value[FRAC_W-1:0];
        cls.is_nan  = exp_ones & frac_nz;
        cls.is_snan = exp_ones & frac_nz & ~value[FRAC_W-1];
    end
endmodule

// File: rtl/nan_pick.sv
// Module: nan_pick
// Chooses where the result comes from: the core, operand A, operand B or a
// created NaN. Operand NaNs take precedence over anything from the core.
// Assumes the classifications come from nan_classify.
module nan_pick (
    input  nan_sel_pkg::nan_class_t cls_a,
    input  nan_sel_pkg::nan_class_t cls_b,
    input  nan_sel_pkg::nan_class_t cls_core,
    input  logic                    core_invalid,
    input  logic                    sig_prio,
    output nan_sel_pkg::nan_src_e   sel
);
    import nan_sel_pkg::*;

    logic a_quiet;
    logic core_made_nan;

    // Apply the operand priority policy, then the created-NaN rule.
    always_comb begin
        a_quiet       = cls_a.is_nan & ~cls_a.is_snan;
        core_made_nan = core_invalid | cls_core.is_nan | cls_core.is_snan;
        if (cls_a.is_nan && cls_b.is_nan) begin
            sel = (sig_prio && a_quiet && cls_b.is_snan) ? SRC_B : SRC_A;
        end else if (cls_a.is_nan) begin
            sel = SRC_A;
        end else if (cls_b.is_nan) begin
            sel = SRC_B;
        end else if (core_made_nan) begin
            sel = SRC_GEN;
        end else begin
            sel = SRC_CORE;
        end
    end
endmodule

// File: rtl/nan_shape.sv
// Module: nan_shape
// Builds the final bit pattern for the chosen source: it sets the quiet bit
// on carried NaNs and forms the default or canonical pattern for created NaNs.
// Assumes sel came from nan_pick for the same operands.
module nan_shape #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W,
    localparam int QBIT  = FRAC_W - 1
) (
    input  nan_sel_pkg::nan_src_e sel,
    input  logic [W-1:0]          op_a,
    input  logic [W-1:0]          op_b,
    input  logic [W-1:0]          core_res,
    input  logic                  sig_prio,
    input  logic                  canon_en,
    output logic [W-1:0]          result,
    output logic                  is_nan
);
    import nan_sel_pkg::*;

    localparam logic [W-1:0] QMASK = W'(1) << QBIT;
    localparam logic [W-2:0] BODY  = {{EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic gen_sign;

    // Select and correct the output pattern.
    always_comb begin
        gen_sign = canon_en ? 1'b0 : ~sig_prio;
        unique case (sel)
            SRC_A:   result = op_a | QMASK;
            SRC_B:   result = op_b | QMASK;
            SRC_GEN: result = {gen_sign, BODY};
            default: result = core_res;
        endcase
        is_nan = (sel != SRC_CORE);
    end
endmodule

// File: rtl/nan_sel_unit.sv
// Module: nan_sel_unit (top)
// NaN propagation selector behind a two-operand floating-point operation.
// Classifies the operands and the core result, picks the source, shapes the
// pattern and registers it with one cycle of latency.
// Assumes a synchronous active-low reset and one operation per valid cycle.
module nan_sel_unit #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [W-1:0] core_res,
    input  logic         core_invalid,
    input  logic         sig_prio,
    input  logic         canon_en,
    output logic         out_valid,
    output logic [W-1:0] res_out,
    output logic         nan_out
);
    import nan_sel_pkg::*;

    localparam int NVAL = 3;

    logic [W-1:0] vals [NVAL];
    nan_class_t   cls  [NVAL];
    nan_src_e     sel;
    logic [W-1:0] shaped;
    logic         shaped_nan;

    // Gather the three values that need classifying.
    always_comb begin
        vals[0] = op_a;
        vals[1] = op_b;
        vals[2] = core_res;
    end

    for (genvar i = 0; i < NVAL; i++) begin : g_cls
        nan_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .value (vals[i]),
            .cls   (cls[i])
        );
    end

    nan_pick u_pick (
        .cls_a        (cls[0]),
        .cls_b        (cls[1]),
        .cls_core     (cls[2]),
        .core_invalid (core_invalid),
        .sig_prio     (sig_prio),
        .sel          (sel)
    );

    nan_shape #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_shape (
        .sel      (sel),
        .op_a     (op_a),
        .op_b     (op_b),
        .core_res (core_res),
        .sig_prio (sig_prio),
        .canon_en (canon_en),
        .result   (shaped),
        .is_nan   (shaped_nan)
    );

    // Output register: capture on valid, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            res_out   <= '0;
            nan_out   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                res_out <= shaped;
                nan_out <= shaped_nan;
            end
        end
    end
endmodule

// File: rtl/nan_sel_chk.sv
// Module: nan_sel_chk
// Assertion checker for nan_sel_unit, attached through bind below.
// Assumes the same port names as the top module.
module nan_sel_chk #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic [W-1:0] core_res,
    input logic         core_invalid,
    input logic         sig_prio,
    input logic         canon_en,
    input logic         out_valid,
    input logic [W-1:0] res_out,
    input logic         nan_out
);
    localparam logic [W-1:0] CANON = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [W-1:0] NEG_DEF = {1'b1, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    function automatic logic nanp(input logic [W-1:0] v);
        return (&v[W-2 -: EXP_W]) && (|v[FRAC_W-1:0]);
    endfunction

    logic no_op_nan;
    logic made;

    // Conditions on the inputs used by several properties.
    always_comb begin
        no_op_nan = !nanp(op_a) && !nanp(op_b);
        made      = no_op_nan && (core_invalid || nanp(core_res));
    end

    p_valid_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && no_op_nan && !core_invalid && !nanp(core_res))
        |=> res_out == $past(core_res));
    p_quiet_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && nan_out) |-> res_out[FRAC_W-1]);
    p_default_neg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && made && !canon_en && !sig_prio) |=> res_out == NEG_DEF);
    p_canon_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && made && canon_en) |=> res_out == CANON);
    p_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (nan_out == nanp(res_out)));
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(res_out) && $stable(nan_out)));
endmodule

bind nan_sel_unit nan_sel_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (.*);

// File: tb/nan_sel_unit_tb.sv
`timescale 1ns/1ps
module nan_sel_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0, op_b = '0, core_res = '0;
    logic        core_invalid = 1'b0, sig_prio = 1'b0, canon_en = 1'b0;
    logic        out_valid;
    logic [31:0] res_out;
    logic        nan_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    nan_sel_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .core_res(core_res), .core_invalid(core_invalid), .sig_prio(sig_prio),
        .canon_en(canon_en), .out_valid(out_valid), .res_out(res_out), .nan_out(nan_out)
    );

    function automatic bit isn(input logic [31:0] v);
        return (v[30:23] == 8'hFF) && (v[22:0] != 0);
    endfunction

    // Reference model written from the requirements.
    function automatic logic [31:0] model(input logic [31:0] a, b, c,
                                          input bit inv, sp, cn);
        bit an = isn(a), bn = isn(b);
        if (an && bn) begin
            if (sp && a[22] && !b[22]) return b | 32'h0040_0000;  // R6
            return a | 32'h0040_0000;                            // R5 / R6
        end
        if (an) return a | 32'h0040_0000;                        // R4
        if (bn) return b | 32'h0040_0000;                        // R4
        if (inv || isn(c)) begin
            if (cn) return 32'h7FC0_0000;                        // R8
            return sp ? 32'h7FC0_0000 : 32'hFFC0_0000;           // R7
        end
        return c;                                                // R3
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // Driver: apply one operation and queue its expected result.
    task automatic drive(input logic [31:0] a, b, c, input bit inv, sp, cn,
                         input string req);
        @(negedge clk);
        op_a = a; op_b = b; core_res = c;
        core_invalid = inv; sig_prio = sp; canon_en = cn;
        in_valid = 1'b1;
        exp_q.push_back(model(a, b, c, inv, sp, cn));
        tag_q.push_back(req);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: compare each produced result against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected out_valid", {31'b0, out_valid}, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(res_out === e, t, res_out, e);
                check(nan_out === isn(e), {t, " R9 flag"}, {31'b0, nan_out}, {31'b0, isn(e)});
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0, "R1 valid", {31'b0, out_valid}, 32'h0);
        check(res_out === 32'h0, "R1 result", res_out, 32'h0);
        check(nan_out === 1'b0, "R1 flag", {31'b0, nan_out}, 32'h0);
        rst_n = 1'b1;

        drive(32'h3F80_0000, 32'h4000_0000, 32'h4040_0000, 0, 0, 0, "R3 normal");
        drive(32'h7F80_0000, 32'h3F80_0000, 32'h7F80_0000, 0, 1, 1, "R3 infinity");
        drive(32'h7F80_0001, 32'h3F80_0000, 32'h1234_5678, 1, 0, 0, "R4 a snan");
        drive(32'h4000_0000, 32'hFFC1_2345, 32'h0, 0, 1, 0, "R4 b qnan neg");
        drive(32'h7F80_0005, 32'h7FC0_0007, 32'h0, 0, 0, 0, "R5 a snan b qnan");
        drive(32'h7FC0_0003, 32'h7F80_0009, 32'h0, 0, 0, 0, "R5 a qnan b snan");
        drive(32'hFFC0_0003, 32'h7F80_0009, 32'h0, 0, 1, 0, "R6 b snan wins");
        drive(32'hFF80_0011, 32'h7FC0_0022, 32'h0, 0, 1, 0, "R6 a snan b qnan");
        drive(32'h7F80_0033, 32'hFF80_0044, 32'h0, 0, 1, 0, "R6 both snan");
        drive(32'hFFC0_0055, 32'h7FC0_0066, 32'h0, 0, 1, 0, "R6 both qnan");
        drive(32'h7F80_0000, 32'h0, 32'h7FC0_0000, 1, 0, 0, "R7 plain default");
        drive(32'h7F80_0000, 32'h0, 32'hFFC0_0000, 1, 1, 0, "R7 sigprio default");
        drive(32'h0, 32'h0, 32'h3F80_0000, 1, 0, 0, "R7 invalid alone");
        drive(32'h0, 32'h0, 32'h7F80_0001, 0, 0, 0, "R7 core snan");
        drive(32'h7F80_0000, 32'h0, 32'hFFC0_0000, 1, 0, 1, "R8 canon plain");
        drive(32'h7F80_0000, 32'h0, 32'hFFC0_0000, 1, 1, 1, "R8 canon sigprio");
        drive(32'hFFC0_0011, 32'h0, 32'h0, 0, 0, 1, "R8 operand keeps sign");
        idle();
        @(negedge clk);
        check(out_valid === 1'b0, "R2 idle valid", {31'b0, out_valid}, 32'h0);
        check(res_out === 32'hFFC0_0011, "R10 hold result", res_out, 32'hFFC0_0011);
        check(nan_out === 1'b1, "R10 hold flag", {31'b0, nan_out}, 32'h1);
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R2 all results seen", exp_q.size(), 32'h0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule